// File: doc/BRIEF.md
# Clock-Generator Control Register Slave on a Two-Wire Bus

This block is the serial control port of a clock generator. It sits on an SMBus/I2C-compatible two-wire bus as a slave. The system clock oversamples the SCL and SDA lines. The block holds eight 8-bit control registers and presents all of them at once on a parallel output bus. The output-enable, stop-select and drive-strength logic of the clock generator reads that bus directly. Reset loads each register with its power-up value, so software never has to touch the port.

A host addresses the slave with the byte 0xD2 for a write or 0xD3 for a read. The byte after the address is a command. Its top bit picks the access type. When that bit is set, the access is a single byte, and the low five bits give the register offset. When it is clear, the access is a block that always starts at register 0. Block writes carry a byte count ahead of the data. Block reads return a count of 8 before the data. A host may end any transfer after a whole byte. Register 7 holds a fixed identification value and cannot be written.

The controller is a state machine with these states:
- IDLE
- ADDR (address shift-in)
- CMD (command shift-in)
- COUNT (byte-count shift-in)
- WDATA (write-data shift-in)
- ACK (slave drives the acknowledge)
- RDATA (slave shifts out a byte)
- MACK (master acknowledge)

The transitions are:
- Start: from any state to ADDR.
- Stop: from any state to IDLE.
- Address match: ADDR to ACK. A mismatch goes to IDLE.
- Command accept: CMD to ACK. A bad chip-select field goes to IDLE.
- Byte done: COUNT or WDATA to ACK.
- Ack release: ACK to CMD, COUNT, WDATA or RDATA.
- Eighth bit out: RDATA to MACK.
- Master ack: MACK to RDATA.
- Master nack: MACK to IDLE.

Top module: `clkgen_smbus_regs`

## Requirements
- R1: The slave acknowledges only the address byte 0xD2 (write) or 0xD3 (read). Any other address gets no acknowledge, and the rest of that transfer changes no register.
- R2: A command byte whose bits 6:5 are not 00 gets no acknowledge, and the rest of that transfer changes no register.
- R3: A command with bit 7 set, followed by one data byte, writes that byte to the register whose offset is in command bits 4:0. Every byte is acknowledged.
- R4: A command with bit 7 set, then a repeated start and address 0xD3, returns the register at offset bits 4:0, MSB first.
- R5: A command with bit 7 clear is followed by a byte count that is acknowledged. The data bytes after it go to registers 0, 1, 2 and so on. A stop after any whole byte leaves the later registers unchanged.
- R6: A block read (command bit 7 clear, then a repeated start and 0xD3) returns the value 8 first, then registers 0, 1, 2 and so on. It continues until the master answers with a NACK.
- R7: After reset, registers 0 to 7 hold 0xFF, 0xFF, 0xEB, 0xAF, 0x03, 0x00, 0x10, 0x18.
- R8: Register 7 always reads 0x18. Writes to offset 7 or to offsets of 8 and above are acknowledged and change nothing. Reads of offsets 8 and above return 0x00.
- R9: After the master NACKs a read byte, the slave does not pull SDA low again until the next start.
- R10: A start or stop condition at any bit position aborts the transfer in progress. A byte cut short by it is not written. A start always begins a new address phase.
- R11: ctrl_regs_o carries register k on bits [8k+7:8k].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low reset; loads the power-up values |
| scl_i | input | 1 | Serial clock line as seen at the pin |
| sda_i | input | 1 | Serial data line as seen at the pin |
| sda_drive_low_o | output | 1 | 1 pulls SDA low (acknowledge or a read bit of 0) |
| ctrl_regs_o | output | 64 | All eight control registers; register k on bits [8k+7:8k] |

## Verification
Each access type is tried on its own:
- byte write and byte read at low, middle, read-only and out-of-range offsets;
- a block write stopped before the end of the bank;
- a full block write;
- block reads of several lengths.

These patterns tell the offset path apart from the sequential pointer, and the count byte apart from register data. Transfers to a foreign address, with a nonzero chip-select field, or cut short mid-byte by a stop show whether the machine really drops back to IDLE. Clocking the bus after a NACK shows whether the slave keeps SDA released.

// File: rtl/clkgen_smbus_pkg.sv
`timescale 1ns/1ps
package clkgen_smbus_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_CMD,
        ST_COUNT,
        ST_WDATA,
        ST_ACK,
        ST_RDATA,
        ST_MACK
    } link_state_t;

    // Power-up value of each control register
    function automatic logic [7:0] reg_default(input int idx);
        case (idx)
            0:       return 8'hFF;  // differential output enables
            1:       return 8'hFF;  // single-ended and CPU enables
            2:       return 8'hEB;  // spread and drive strengths
            3:       return 8'hAF;  // stop drive mode
            4:       return 8'h03;  // stop select, request line 0
            5:       return 8'h00;  // stop select, request line 1
            6:       return 8'h10;  // test and reference drive
            7:       return 8'h18;  // revision / vendor identification
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/clkgen_line_sync.sv
`timescale 1ns/1ps
module clkgen_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det,
    output logic sda_s
);
    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_q;
    logic              sda_q;
    logic              scl_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
            scl_q    <= scl_pipe[STAGES-1];
            sda_q    <= sda_pipe[STAGES-1];
        end
    end

    assign scl_s     = scl_pipe[STAGES-1];
    assign sda_s     = sda_pipe[STAGES-1];
    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    assign start_det = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/clkgen_reg_bank.sv
`timescale 1ns/1ps
module clkgen_reg_bank
    import clkgen_smbus_pkg::*;
#(
    parameter int NUM_REGS = 8,
    parameter int RO_INDEX = 7,
    parameter int IDX_W    = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [IDX_W-1:0]      wr_idx,
    input  logic [7:0]            wr_data,
    input  logic [IDX_W-1:0]      rd_idx,
    output logic [7:0]            rd_data,
    output logic [NUM_REGS*8-1:0] regs_flat
);
    localparam int SEL_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

    logic [7:0] bank [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        if (g == RO_INDEX) begin : g_ro
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) bank[g] <= reg_default(g);
            end
        end else begin : g_rw
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    bank[g] <= reg_default(g);
                else if (wr_en && (wr_idx == IDX_W'(g)))
                    bank[g] <= wr_data;
            end
        end
        assign regs_flat[g*8 +: 8] = bank[g];
    end

    always_comb begin
        rd_data = 8'h00;
        if (int'(rd_idx) < NUM_REGS)
            rd_data = bank[rd_idx[SEL_W-1:0]];
    end

endmodule

// File: rtl/clkgen_smbus_regs.sv
`timescale 1ns/1ps
module clkgen_smbus_regs
    import clkgen_smbus_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h69,
    parameter int         NUM_REGS    = 8,
    parameter int         RO_INDEX    = 7,
    parameter logic [7:0] BLOCK_COUNT = 8'd8,
    parameter int         SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scl_i,
    input  logic                  sda_i,
    output logic                  sda_drive_low_o,
    output logic [NUM_REGS*8-1:0] ctrl_regs_o
);
    localparam int IDX_W = 5;

    logic scl_rise, scl_fall, start_det, stop_det, sda_s;

    link_state_t      state, state_n, after_ack, after_n;
    logic [3:0]       bit_cnt, bit_n;
    logic [7:0]       shreg, shreg_n;
    logic [IDX_W-1:0] ptr, ptr_n;
    logic             blk_mode, blk_n;
    logic             cnt_pend, cnt_pend_n;
    logic             mnack, mnack_n;
    logic             wr_en;
    logic [7:0]       rd_data;

    clkgen_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det), .sda_s(sda_s)
    );

    clkgen_reg_bank #(.NUM_REGS(NUM_REGS), .RO_INDEX(RO_INDEX), .IDX_W(IDX_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(ptr), .wr_data(shreg),
        .rd_idx(ptr), .rd_data(rd_data), .regs_flat(ctrl_regs_o)
    );

    function automatic logic [IDX_W-1:0] ptr_step(input logic [IDX_W-1:0] p);
        return (p == '1) ? p : p + 1'b1;
    endfunction

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            after_ack <= ST_IDLE;
            bit_cnt   <= '0;
            shreg     <= '0;
            ptr       <= '0;
            blk_mode  <= 1'b1;
            cnt_pend  <= 1'b0;
            mnack     <= 1'b0;
        end else begin
            state     <= state_n;
            after_ack <= after_n;
            bit_cnt   <= bit_n;
            shreg     <= shreg_n;
            ptr       <= ptr_n;
            blk_mode  <= blk_n;
            cnt_pend  <= cnt_pend_n;
            mnack     <= mnack_n;
        end
    end

    // Next-state and datapath decisions
    always_comb begin
        state_n    = state;
        after_n    = after_ack;
        bit_n      = bit_cnt;
        shreg_n    = shreg;
        ptr_n      = ptr;
        blk_n      = blk_mode;
        cnt_pend_n = cnt_pend;
        mnack_n    = mnack;
        wr_en      = 1'b0;
        if (stop_det) begin
            state_n = ST_IDLE;
        end else if (start_det) begin
            state_n = ST_ADDR;
            bit_n   = '0;
        end else begin
            unique case (state)
                ST_IDLE: ;
                ST_ADDR, ST_CMD, ST_COUNT, ST_WDATA: begin
                    if (scl_rise) begin
                        shreg_n = {shreg[6:0], sda_s};
                        bit_n   = bit_cnt + 4'd1;
                    end else if (scl_fall && bit_cnt == 4'd8) begin
                        bit_n   = '0;
                        state_n = ST_ACK;
                        if (state == ST_ADDR) begin
                            if (shreg[7:1] != DEV_ADDR) begin
                                state_n = ST_IDLE;
                            end else if (shreg[0]) begin
                                after_n    = ST_RDATA;
                                cnt_pend_n = blk_mode;
                            end else begin
                                after_n = ST_CMD;
                            end
                        end else if (state == ST_CMD) begin
                            if (shreg[6:5] != 2'b00) begin
                                state_n = ST_IDLE;
                            end else begin
                                blk_n   = ~shreg[7];
                                ptr_n   = shreg[7] ? shreg[4:0] : '0;
                                after_n = shreg[7] ? ST_WDATA : ST_COUNT;
                            end
                        end else if (state == ST_COUNT) begin
                            after_n = ST_WDATA;
                        end else begin
                            wr_en   = 1'b1;
                            ptr_n   = ptr_step(ptr);
                            after_n = ST_WDATA;
                        end
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        state_n = after_ack;
                        bit_n   = '0;
                        if (after_ack == ST_RDATA) begin
                            if (cnt_pend) begin
                                shreg_n    = BLOCK_COUNT;
                                cnt_pend_n = 1'b0;
                            end else begin
                                shreg_n = rd_data;
                                ptr_n   = ptr_step(ptr);
                            end
                        end
                    end
                end
                ST_RDATA: begin
                    if (scl_fall) begin
                        if (bit_cnt == 4'd7) begin
                            state_n = ST_MACK;
                            bit_n   = '0;
                        end else begin
                            shreg_n = {shreg[6:0], 1'b0};
                            bit_n   = bit_cnt + 4'd1;
                        end
                    end
                end
                ST_MACK: begin
                    if (scl_rise) begin
                        mnack_n = sda_s;
                    end else if (scl_fall) begin
                        if (mnack) begin
                            state_n = ST_IDLE;
                        end else begin
                            state_n = ST_RDATA;
                            shreg_n = rd_data;
                            ptr_n   = ptr_step(ptr);
                        end
                    end
                end
                default: state_n = ST_IDLE;
            endcase
        end
    end

    // Outputs
    always_comb begin
        sda_drive_low_o = (state == ST_ACK) || (state == ST_RDATA && !shreg[7]);
    end

endmodule

// File: rtl/clkgen_smbus_regs_chk.sv
`timescale 1ns/1ps
module clkgen_smbus_regs_chk
    import clkgen_smbus_pkg::*;
#(
    parameter int NUM_REGS = 8,
    parameter int RO_INDEX = 7
) (
    input logic                  clk,
    input logic                  rst_n,
    input link_state_t           state,
    input logic                  start_det,
    input logic                  stop_det,
    input logic                  sda_drive_low_o,
    input logic [NUM_REGS*8-1:0] ctrl_regs_o
);
    assert_stop_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (state == ST_IDLE));

    assert_start_addr_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (start_det && !stop_det) |=> (state == ST_ADDR));

    assert_idle_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !sda_drive_low_o);

    assert_write_from_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ctrl_regs_o) |-> ($past(state) == ST_WDATA));

    assert_id_fixed_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_regs_o[RO_INDEX*8 +: 8] == reg_default(RO_INDEX));

endmodule

bind clkgen_smbus_regs clkgen_smbus_regs_chk #(
    .NUM_REGS(NUM_REGS), .RO_INDEX(RO_INDEX)
) u_chk (
    .clk(clk), .rst_n(rst_n), .state(state), .start_det(start_det),
    .stop_det(stop_det), .sda_drive_low_o(sda_drive_low_o), .ctrl_regs_o(ctrl_regs_o)
);

// File: tb/clkgen_smbus_regs_test.sv
`timescale 1ns/1ps
module clkgen_smbus_regs_test;
    localparam int Q = 80;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic sda_drive_low;
    logic [63:0] regs;
    wire sda_line = sda_m & ~sda_drive_low;

    always #4 clk = ~clk;

    clkgen_smbus_regs uut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
        .sda_drive_low_o(sda_drive_low), .ctrl_regs_o(regs)
    );

    int checks = 0;
    int errors = 0;
    logic [7:0] model [8];
    logic [7:0] exp_q [$];
    string      tag_q [$];
    logic [7:0] got_q [$];
    logic watch = 1'b0;
    logic pulled = 1'b0;
    logic ack;

    always @(negedge clk) if (watch && sda_drive_low) pulled = 1'b1;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Monitor: compares every byte read from the slave against the expectation queue
    initial begin
        forever begin
            wait (got_q.size() != 0);
            begin
                logic [7:0] g;
                logic [7:0] e;
                string t;
                g = got_q.pop_front();
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(t, {56'd0, g}, {56'd0, e});
            end
        end
    end

    task automatic expect_byte(input logic [7:0] v, input string t);
        exp_q.push_back(v);
        tag_q.push_back(t);
    endtask

    task automatic bit_out(input logic b);
        sda_m = b; #(Q); scl = 1'b1; #(2*Q); scl = 1'b0; #(Q);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; #(Q); scl = 1'b1; #(Q); sda_m = 1'b0; #(Q); scl = 1'b0; #(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; #(Q); scl = 1'b1; #(Q); sda_m = 1'b1; #(2*Q);
    endtask

    task automatic send(input logic [7:0] b, output logic a);
        for (int i = 7; i >= 0; i--) bit_out(b[i]);
        sda_m = 1'b1; #(Q); scl = 1'b1; #(Q); a = ~sda_line; #(Q); scl = 1'b0; #(Q);
    endtask

    task automatic recv(input logic mack);
        logic [7:0] b;
        for (int i = 7; i >= 0; i--) begin
            sda_m = 1'b1; #(Q); scl = 1'b1; #(Q); b[i] = sda_line; #(Q); scl = 1'b0; #(Q);
        end
        bit_out(~mack);
        got_q.push_back(b);
    endtask

    task automatic check_regs(input string t);
        for (int k = 0; k < 8; k++) check(t, {56'd0, regs[8*k +: 8]}, {56'd0, model[k]});
    endtask

    task automatic byte_write(input logic [4:0] off, input logic [7:0] d, input string t);
        bus_start();
        send(8'hD2, ack); check({t, " addr ack"}, {63'd0, ack}, 64'd1);
        send({3'b100, off}, ack); check({t, " cmd ack"}, {63'd0, ack}, 64'd1);
        send(d, ack); check({t, " data ack"}, {63'd0, ack}, 64'd1);
        bus_stop();
        if (off < 7) model[off] = d;
    endtask

    task automatic byte_read(input logic [4:0] off, input string t);
        bus_start();
        send(8'hD2, ack);
        send({3'b100, off}, ack);
        bus_start();
        send(8'hD3, ack); check({t, " read addr ack"}, {63'd0, ack}, 64'd1);
        expect_byte((off < 8) ? model[off] : 8'h00, t);
        recv(1'b0);
        bus_stop();
    endtask

    task automatic block_read(input int n, input string t);
        bus_start();
        send(8'hD2, ack);
        send(8'h00, ack); check({t, " cmd ack"}, {63'd0, ack}, 64'd1);
        bus_start();
        send(8'hD3, ack);
        expect_byte(8'd8, {t, " count"});
        for (int i = 0; i < n; i++) expect_byte(model[i], t);
        for (int i = 0; i <= n; i++) recv(i != n);
        bus_stop();
    endtask

    initial begin
        model[0] = 8'hFF; model[1] = 8'hFF; model[2] = 8'hEB; model[3] = 8'hAF;
        model[4] = 8'h03; model[5] = 8'h00; model[6] = 8'h10; model[7] = 8'h18;
        #(2*Q); rst_n = 1'b1; #(2*Q);

        check_regs("R7 R11 reset value");
        check("R7 SDA released", {63'd0, sda_drive_low}, 64'd0);

        byte_read(5'd2, "R4 byte read offset 2");
        byte_write(5'd4, 8'h5A, "R3 byte write offset 4");
        check_regs("R3 R11 after byte write");
        byte_read(5'd4, "R4 readback offset 4");

        // R1: foreign address
        bus_start();
        send(8'hA0, ack); check("R1 foreign address not acked", {63'd0, ack}, 64'd0);
        send(8'h81, ack); send(8'h00, ack);
        bus_stop();
        check_regs("R1 registers untouched");

        // R2: chip-select field nonzero
        bus_start();
        send(8'hD2, ack); check("R2 addr ack", {63'd0, ack}, 64'd1);
        send(8'hA1, ack); check("R2 bad chip select not acked", {63'd0, ack}, 64'd0);
        send(8'h00, ack);
        bus_stop();
        check_regs("R2 registers untouched");

        // R5: block write of 3 bytes
        bus_start();
        send(8'hD2, ack);
        send(8'h00, ack); check("R5 block cmd ack", {63'd0, ack}, 64'd1);
        send(8'h03, ack); check("R5 count ack", {63'd0, ack}, 64'd1);
        send(8'h11, ack); send(8'h22, ack); send(8'h33, ack);
        check("R5 last data ack", {63'd0, ack}, 64'd1);
        bus_stop();
        model[0] = 8'h11; model[1] = 8'h22; model[2] = 8'h33;
        check_regs("R5 partial block write");

        block_read(3, "R6 block read short");

        // R8: full block write reaches the read-only byte
        bus_start();
        send(8'hD2, ack); send(8'h00, ack); send(8'h08, ack);
        for (int i = 0; i < 8; i++) begin
            send(8'hC0 + 8'(i), ack);
            if (i < 7) model[i] = 8'hC0 + 8'(i);
        end
        check("R8 write to id byte acked", {63'd0, ack}, 64'd1);
        bus_stop();
        check_regs("R5 R8 full block write");
        block_read(8, "R6 block read full");

        byte_write(5'd7, 8'h00, "R8 write id byte");
        byte_write(5'd9, 8'h77, "R8 write offset 9");
        check_regs("R8 ignored writes");
        byte_read(5'd9, "R8 read offset 9");
        byte_read(5'd7, "R8 read id byte");

        // R9: clocking after NACK must not draw SDA low
        bus_start();
        send(8'hD2, ack); send(8'h81, ack);
        bus_start();
        send(8'hD3, ack);
        expect_byte(model[1], "R9 byte before nack");
        recv(1'b0);
        pulled = 1'b0; watch = 1'b1;
        for (int i = 0; i < 9; i++) bit_out(1'b1);
        watch = 1'b0;
        check("R9 SDA stays released after nack", {63'd0, pulled}, 64'd0);
        bus_stop();

        // R10: stop in the middle of a data byte
        bus_start();
        send(8'hD2, ack); send(8'h81, ack);
        bit_out(1'b0); bit_out(1'b0); bit_out(1'b0); bit_out(1'b0);
        bus_stop();
        check_regs("R10 aborted byte not written");
        // R10: start in the middle of an address byte, then a fresh transfer
        bus_start();
        bit_out(1'b1); bit_out(1'b1); bit_out(1'b0);
        bus_start();
        send(8'hD2, ack); check("R10 restart address ack", {63'd0, ack}, 64'd1);
        send(8'h86, ack); send(8'h3C, ack);
        bus_stop();
        model[6] = 8'h3C;
        check_regs("R10 R3 transfer after restart");

        #(4*Q);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 8);
        checks++;
        errors++;
        $display("FAIL watchdog actual hung expected done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule